// File: doc/BRIEF.md
# Power Mode State Controller

This block decides which power mode a supply-management chip is in. There are four modes: ACTIVE, RETENTION, STANDBY and a deeper low-power standby. The mode changes on a falling or rising enable pin, on a trigger bit written over a small register port, on falling edges of wake pins, on a timer or alarm pulse, and on a two-bit sleep-control field. The block drives one enable line per processor regulator. These lines step off one per clock when the chip leaves ACTIVE and step back on in reverse order when it returns. While a step sequence runs, a busy flag is high.

How the chip leaves standby depends on what put it there. After an enable-pin entry, only the rising enable pin brings it back. After a register-triggered entry, only a wake pin that is enabled for wake, or the timer pulse, brings it back. A select bit decides whether a standby request goes to normal standby or to the deeper low-power standby. Falling edges on the wake pins also set sticky interrupt flags. These flags are cleared by writing 1 to them and are reported on an interrupt line unless they are masked.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is ACTIVE (code 2'b00), every regulator enable is 1, busy is 0 and irq is 0. The control register (address 0) reads 0x0E and the wake register (address 1) reads 0x30.
- R2: In ACTIVE or RETENTION (2'b01), a falling enable pin or a write with bit 0 set to address 2 moves the mode on the next clock. With control bit 0 (low-power select) clear it goes to STANDBY (2'b10); with it set it goes to low-power standby (2'b11).
- R3: Leaving ACTIVE raises busy for NUM_REG cycles, and the regulator enables clear one per clock from bit 0 upward. Entering ACTIVE from any other mode sets them one per clock from bit NUM_REG-1 downward. Outside a sequence every enable is 1 in ACTIVE and 0 in every other mode.
- R4: After an enable-pin entry, the rising enable pin returns the chip to ACTIVE. Wake-pin edges and the timer pulse leave the mode unchanged.
- R5: After a register entry, ACTIVE is reached by a falling edge on a wake pin whose enable bit (address 1, bit i) is set, or by a timer pulse. The enable pin and wake pins with a clear enable bit are ignored.
- R6: The standby modes are entered only from ACTIVE or RETENTION and are left only to ACTIVE. Entry from RETENTION runs no sequence.
- R7: A falling edge on wake pin i sets flag i (address 3, bit i). The flag holds until 1 is written to that bit. irq is high when any flag is set whose mask bit (address 1, bit 4+i) is 0.
- R8: When control bit 1 (field mask) is 0 in ACTIVE or RETENTION, the field in control bits 3:2 selects the mode: 2'b11 ACTIVE, 2'b10 or 2'b01 RETENTION, 2'b00 a register-type standby entry. With the mask at 1, or in a standby mode, the field has no effect.
- R9: A trigger that arrives while busy is held and takes effect on the first clock after busy falls.
- R10: The status register (address 4) reads the mode in bits 1:0, busy in bit 2 and, in bit 3, whether the last standby entry came from the enable pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enPin | input | 1 | Enable pin, synchronous to clk |
| wakePin | input | NUM_WAKE | Wake pins, falling edge active |
| timerWake | input | 1 | Timer or alarm wake pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| regEn | output | NUM_REG | Regulator enable lines |
| curMode | output | 2 | Current power mode |
| busy | output | 1 | Step sequence in progress |
| irq | output | 1 | Unmasked wake interrupt pending |

## Verification
The assertions assume that enPin, wakePin and timerWake are already synchronous to clk and change only once per cycle. They also assume that no register write is in flight during reset. The bench drives every input on the falling clock edge, holds each pin level for at least one full cycle, and returns the wake pins high between pulses. This keeps every edge the block detects a single, clean event.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_WAKE   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TRIG   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;

  localparam int MASK_LSB = 4;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_RETAIN = 2'b01,
    MODE_STBY   = 2'b10,
    MODE_LPSTBY = 2'b11
  } pwrMode_e;

  typedef struct packed {
    logic seqGo;
    logic seqUp;
  } seqCmd_t;

  typedef struct packed {
    logic       enFall;
    logic       enRise;
    logic       busTrig;
    logic       wake;
    logic       lpSel;
    logic       fieldOn;
    logic [1:0] field;
    logic       busy;
  } dpEvents_t;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int NUM_REG  = 4,
  parameter int NUM_WAKE = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enPin,
  input  logic [NUM_WAKE-1:0] wakePin,
  input  logic                timerWake,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  seqCmd_t             cmd,
  input  pwrMode_e            curMode,
  input  logic                srcPin,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_REG-1:0]  regEn,
  output logic                busy,
  output logic                irq,
  output logic [NUM_WAKE-1:0] wakeFlags,
  output dpEvents_t           ev
);

  localparam int CNT_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_REG - 1);

  // pin edge detection
  logic                prevEn;
  logic [NUM_WAKE-1:0] prevWake;
  logic [NUM_WAKE-1:0] wakeFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEn   <= 1'b1;
      prevWake <= '1;
    end else begin
      prevEn   <= enPin;
      prevWake <= wakePin;
    end
  end

  assign wakeFall = prevWake & ~wakePin;

  // configuration registers
  logic                lpSel;
  logic                sleepMask;
  logic [1:0]          sleepField;
  logic [NUM_WAKE-1:0] wakeCfg;
  logic [NUM_WAKE-1:0] intMask;

  logic wrCtrl, wrWake, wrFlag, busTrig;
  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrWake  = regWrEn && (regAddr == ADDR_WAKE);
  assign wrFlag  = regWrEn && (regAddr == ADDR_FLAG);
  assign busTrig = regWrEn && (regAddr == ADDR_TRIG) && regWrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lpSel      <= 1'b0;
      sleepMask  <= 1'b1;
      sleepField <= 2'b11;
      wakeCfg    <= '0;
      intMask    <= '1;
    end else begin
      if (wrCtrl) begin
        lpSel      <= regWrData[0];
        sleepMask  <= regWrData[1];
        sleepField <= regWrData[3:2];
      end
      if (wrWake) begin
        wakeCfg <= regWrData[NUM_WAKE-1:0];
        intMask <= regWrData[MASK_LSB +: NUM_WAKE];
      end
    end
  end

  // sticky wake flags, a new edge wins over a clear in the same cycle
  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wakeFlags[i] <= 1'b0;
      end else if (wakeFall[i]) begin
        wakeFlags[i] <= 1'b1;
      end else if (wrFlag && regWrData[i]) begin
        wakeFlags[i] <= 1'b0;
      end
    end
  end

  assign irq = |(wakeFlags & ~intMask);

  // regulator step sequencer
  logic [CNT_W-1:0] stepCnt;
  logic             seqUp;
  logic [CNT_W-1:0] stepIdx;

  assign stepIdx = seqUp ? (LAST_STEP - stepCnt) : stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      seqUp   <= 1'b0;
      regEn   <= '1;
    end else if (cmd.seqGo) begin
      busy    <= 1'b1;
      stepCnt <= '0;
      seqUp   <= cmd.seqUp;
    end else if (busy) begin
      regEn[stepIdx] <= seqUp;
      if (stepCnt == LAST_STEP) begin
        busy <= 1'b0;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  // read port
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[0]   = lpSel;
        regRdData[1]   = sleepMask;
        regRdData[3:2] = sleepField;
      end
      ADDR_WAKE: begin
        regRdData[NUM_WAKE-1:0]          = wakeCfg;
        regRdData[MASK_LSB +: NUM_WAKE] = intMask;
      end
      ADDR_FLAG: begin
        regRdData[NUM_WAKE-1:0] = wakeFlags;
      end
      ADDR_STATUS: begin
        regRdData[1:0] = curMode;
        regRdData[2]   = busy;
        regRdData[3]   = srcPin;
      end
      default: regRdData = '0;
    endcase
  end

  // events towards the control
  always_comb begin
    ev.enFall  = prevEn & ~enPin;
    ev.enRise  = ~prevEn & enPin;
    ev.busTrig = busTrig;
    ev.wake    = (|(wakeFall & wakeCfg)) | timerWake;
    ev.lpSel   = lpSel;
    ev.fieldOn = ~sleepMask;
    ev.field   = sleepField;
    ev.busy    = busy;
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpEvents_t ev,
  output pwrMode_e  mode,
  output logic      srcPin,
  output seqCmd_t   cmd
);

  logic pendFall, pendRise, pendBus, pendWake;
  logic effFall, effRise, effBus, effWake;
  pwrMode_e nextMode;
  pwrMode_e stbyKind;
  logic     nextSrc;

  always_comb begin
    effFall  = pendFall | ev.enFall;
    effRise  = pendRise | ev.enRise;
    effBus   = pendBus  | ev.busTrig;
    effWake  = pendWake | ev.wake;
    stbyKind = ev.lpSel ? MODE_LPSTBY : MODE_STBY;
    nextMode = mode;
    nextSrc  = srcPin;
    cmd      = '0;
    if (!ev.busy) begin
      case (mode)
        MODE_ACTIVE, MODE_RETAIN: begin
          if (effFall || effBus) begin
            nextMode  = stbyKind;
            nextSrc   = effFall;
            cmd.seqGo = (mode == MODE_ACTIVE);
          end else if (ev.fieldOn) begin
            if (ev.field == 2'b11) begin
              if (mode == MODE_RETAIN) begin
                nextMode  = MODE_ACTIVE;
                cmd.seqGo = 1'b1;
                cmd.seqUp = 1'b1;
              end
            end else if (ev.field == 2'b00) begin
              nextMode  = stbyKind;
              nextSrc   = 1'b0;
              cmd.seqGo = (mode == MODE_ACTIVE);
            end else if (mode == MODE_ACTIVE) begin
              nextMode  = MODE_RETAIN;
              cmd.seqGo = 1'b1;
            end
          end
        end
        default: begin
          if (srcPin ? effRise : effWake) begin
            nextMode  = MODE_ACTIVE;
            cmd.seqGo = 1'b1;
            cmd.seqUp = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_ACTIVE;
      srcPin   <= 1'b0;
      pendFall <= 1'b0;
      pendRise <= 1'b0;
      pendBus  <= 1'b0;
      pendWake <= 1'b0;
    end else begin
      mode   <= nextMode;
      srcPin <= nextSrc;
      if (ev.busy) begin
        pendFall <= effFall;
        pendRise <= effRise;
        pendBus  <= effBus;
        pendWake <= effWake;
      end else begin
        pendFall <= 1'b0;
        pendRise <= 1'b0;
        pendBus  <= 1'b0;
        pendWake <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_REG  = 4,
  parameter int NUM_WAKE = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enPin,
  input  logic [NUM_WAKE-1:0] wakePin,
  input  logic                timerWake,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  output logic [NUM_REG-1:0]  regEn,
  output logic [1:0]          curMode,
  output logic                busy,
  output logic                irq
);

  seqCmd_t             seqCmd;
  dpEvents_t           dpEv;
  pwrMode_e            modeQ;
  logic                srcPin;
  logic [NUM_WAKE-1:0] wakeFlags;

  pwr_mode_fsm u_fsm (
    .clk    (clk),
    .rstN   (rstN),
    .ev     (dpEv),
    .mode   (modeQ),
    .srcPin (srcPin),
    .cmd    (seqCmd)
  );

  pwr_mode_dp #(
    .NUM_REG  (NUM_REG),
    .NUM_WAKE (NUM_WAKE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .enPin     (enPin),
    .wakePin   (wakePin),
    .timerWake (timerWake),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .cmd       (seqCmd),
    .curMode   (modeQ),
    .srcPin    (srcPin),
    .regRdData (regRdData),
    .regEn     (regEn),
    .busy      (busy),
    .irq       (irq),
    .wakeFlags (wakeFlags),
    .ev        (dpEv)
  );

  assign curMode = modeQ;

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_mode_pkg::*;
#(
  parameter int NUM_REG  = 4,
  parameter int NUM_WAKE = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          curMode,
  input logic                busy,
  input logic [NUM_REG-1:0]  regEn,
  input logic [NUM_WAKE-1:0] flags,
  input logic                regWrEn,
  input logic [2:0]          regAddr
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic inStby;
  assign inStby = curMode[1];

  // R3: at most one regulator line moves per clock
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ($countones(regEn ^ $past(regEn)) <= 1));

  // R3: settled state of the regulator lines follows the mode
  a_r3_settled: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && curMode == MODE_ACTIVE) |-> (regEn == '1));

  a_r3_settled_off: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && curMode != MODE_ACTIVE) |-> (regEn == '0));

  // R6: standby exits only to ACTIVE
  a_r6_exit_active: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(curMode[1]) && (curMode != $past(curMode))) |-> (curMode == MODE_ACTIVE));

  // R6: standby entered only from ACTIVE or RETENTION
  a_r6_entry_src: assert property (@(posedge clk) disable iff (!rstN)
    (armed && inStby && (curMode != $past(curMode))) |-> !$past(curMode[1]));

  // R9: mode holds while a sequence is running
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(busy) && busy) |-> $stable(curMode));

  // R7: a flag drops only after a write to the flag address
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (($past(flags) & ~flags) != '0)) |-> ($past(regWrEn) && $past(regAddr) == ADDR_FLAG));

endmodule

bind pwr_mode_ctrl pwr_mode_chk #(
  .NUM_REG  (NUM_REG),
  .NUM_WAKE (NUM_WAKE)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .curMode (curMode),
  .busy    (busy),
  .regEn   (regEn),
  .flags   (wakeFlags),
  .regWrEn (regWrEn),
  .regAddr (regAddr)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int WD_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enPin = 1'b1;
  logic [1:0] wakePin = 2'b11;
  logic       timerWake = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [NREG-1:0] regEn;
  logic [1:0] curMode;
  logic       busy;
  logic       irq;

  pwr_mode_ctrl #(.NUM_REG(NREG), .NUM_WAKE(2)) i_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .enPin(enPin), .wakePin(wakePin),
    .timerWake(timerWake), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .regEn(regEn),
    .curMode(curMode), .busy(busy), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] val;
  } expItem_t;

  expItem_t scq[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int S_MODE = 0, S_BUSY = 1, S_REG = 2, S_IRQ = 3, S_RD = 4;

  // monitor: pops expected items and compares after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scq.size() > 0) begin
        expItem_t it;
        logic [31:0] got;
        it = scq.pop_front();
        case (it.sel)
          S_MODE:  got = 32'(curMode);
          S_BUSY:  got = 32'(busy);
          S_REG:   got = 32'(regEn);
          S_IRQ:   got = 32'(irq);
          default: got = 32'(regRdData);
        endcase
        checks++;
        if (got !== it.val) begin
          errors++;
          $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.tag, it.sel, got, it.val);
        end
      end
    end
  end

  task automatic expect_v(input string tag, input int sel, input logic [31:0] v);
    expItem_t it;
    it.tag = tag; it.sel = sel; it.val = v;
    scq.push_back(it);
  endtask

  task automatic expect_rd(input string tag, input logic [2:0] a, input logic [7:0] v);
    regAddr = a;
    expect_v(tag, S_RD, 32'(v));
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    expect_v("R1 mode", S_MODE, 0);
    expect_v("R1 regEn", S_REG, 32'hF);
    expect_v("R1 busy", S_BUSY, 0);
    expect_v("R1 irq", S_IRQ, 0);
    expect_rd("R1 ctrl", 3'd0, 8'h0E);
    tick(1);
    expect_rd("R1 wake", 3'd1, 8'h30);
    tick(1);
    wr(3'd1, 8'h33);

    // pin-caused standby entry
    enPin = 1'b0;
    tick(1);
    expect_v("R2 pin entry", S_MODE, 2);
    expect_v("R3 busy start", S_BUSY, 1);
    expect_v("R3 step0", S_REG, 32'hF);
    tick(1); expect_v("R3 step1", S_REG, 32'hE);
    tick(1); expect_v("R3 step2", S_REG, 32'hC);
    tick(1); expect_v("R3 step3", S_REG, 32'h8);
    tick(1);
    expect_v("R3 all off", S_REG, 32'h0);
    expect_v("R3 busy end", S_BUSY, 0);
    expect_rd("R10 status pin", 3'd4, 8'h0A);
    wakePin = 2'b10;
    tick(2);
    expect_v("R4 wake pin ignored", S_MODE, 2);
    wakePin = 2'b11;
    timerWake = 1'b1;
    tick(1);
    timerWake = 1'b0;
    tick(1);
    expect_v("R4 timer ignored", S_MODE, 2);
    expect_rd("R7 flag set", 3'd3, 8'h01);
    expect_v("R7 masked irq", S_IRQ, 0);
    enPin = 1'b1;
    tick(1);
    expect_v("R4 pin exit", S_MODE, 0);
    expect_v("R3 up busy", S_BUSY, 1);
    expect_v("R3 up start", S_REG, 32'h0);
    tick(1); expect_v("R3 up1", S_REG, 32'h8);
    tick(1); expect_v("R3 up2", S_REG, 32'hC);
    tick(1); expect_v("R3 up3", S_REG, 32'hE);
    tick(1);
    expect_v("R3 up done", S_REG, 32'hF);
    expect_v("R3 up busy end", S_BUSY, 0);
    tick(1);

    // interrupt mask and clear
    wr(3'd1, 8'h23);
    expect_v("R7 unmasked irq", S_IRQ, 1);
    tick(1);
    wr(3'd3, 8'h01);
    expect_v("R7 cleared irq", S_IRQ, 0);
    expect_rd("R7 flag cleared", 3'd3, 8'h00);
    tick(1);

    // register-caused entry into low-power standby
    wr(3'd0, 8'h0F);
    wr(3'd2, 8'h01);
    expect_v("R2 lp entry", S_MODE, 3);
    expect_v("R2 lp busy", S_BUSY, 1);
    tick(4);
    expect_v("R3 lp off", S_REG, 32'h0);
    expect_rd("R10 status bus", 3'd4, 8'h03);
    enPin = 1'b0;
    tick(1);
    enPin = 1'b1;
    tick(2);
    expect_v("R5 enable ignored", S_MODE, 3);
    wr(3'd1, 8'h21);
    wakePin = 2'b01;
    tick(2);
    expect_v("R5 disabled pin ignored", S_MODE, 3);
    wakePin = 2'b11;
    expect_rd("R7 pin1 flag", 3'd3, 8'h02);
    expect_v("R7 pin1 masked", S_IRQ, 0);
    tick(1);
    wakePin = 2'b10;
    tick(1);
    expect_v("R5 wake pin exit", S_MODE, 0);
    expect_v("R5 wake busy", S_BUSY, 1);
    expect_v("R7 pin0 irq", S_IRQ, 1);
    wakePin = 2'b11;
    tick(4);
    expect_v("R3 wake on", S_REG, 32'hF);
    wr(3'd3, 8'h03);
    expect_v("R7 clear both", S_IRQ, 0);

    // timer wake after register entry
    wr(3'd0, 8'h0E);
    wr(3'd2, 8'h01);
    expect_v("R2 stby entry", S_MODE, 2);
    tick(4);
    timerWake = 1'b1;
    tick(1);
    timerWake = 1'b0;
    expect_v("R5 timer exit", S_MODE, 0);
    tick(4);
    expect_v("R5 timer on", S_REG, 32'hF);

    // trigger held during a sequence
    wr(3'd2, 8'h01);
    expect_v("R9 entry", S_MODE, 2);
    timerWake = 1'b1;
    tick(1);
    timerWake = 1'b0;
    tick(3);
    expect_v("R9 held mode", S_MODE, 2);
    expect_v("R9 held busy", S_BUSY, 0);
    expect_v("R9 held regs", S_REG, 32'h0);
    tick(1);
    expect_v("R9 held wake acted", S_MODE, 0);
    expect_v("R9 up busy", S_BUSY, 1);
    tick(4);

    // sleep-control field
    wr(3'd0, 8'h08);
    expect_v("R8 not yet", S_MODE, 0);
    tick(1);
    expect_v("R8 retention", S_MODE, 1);
    expect_v("R8 ret busy", S_BUSY, 1);
    tick(4);
    expect_v("R8 ret off", S_REG, 32'h0);
    wr(3'd0, 8'h02);
    tick(2);
    expect_v("R8 masked ignored", S_MODE, 1);
    enPin = 1'b0;
    tick(1);
    expect_v("R6 from retention", S_MODE, 2);
    expect_v("R6 no sequence", S_BUSY, 0);
    enPin = 1'b1;
    tick(1);
    expect_v("R6 exit active", S_MODE, 0);
    tick(4);
    expect_v("R6 on again", S_REG, 32'hF);
    wr(3'd0, 8'h00);
    tick(1);
    expect_v("R8 field standby", S_MODE, 2);
    tick(4);
    expect_rd("R10 status field", 3'd4, 8'h02);
    tick(1);
    wr(3'd0, 8'h0C);
    tick(2);
    expect_v("R8 field in standby ignored", S_MODE, 2);
    timerWake = 1'b1;
    tick(1);
    timerWake = 1'b0;
    expect_v("R8 wake", S_MODE, 0);
    tick(8);
    expect_v("R8 stays active", S_MODE, 0);
    expect_v("R8 regs on", S_REG, 32'hF);
    tick(2);

    done = 1;
    summary();
    $finish;
  end

endmodule